// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block runs the multi-cycle memory sequence a processor core needs when it takes a hardware interrupt and when it returns from one. When the core accepts a request whose service-select bit is clear, the sequencer captures the core's dedicated registers and writes them as a twelve-byte frame onto a byte-wide system stack, one byte per clock. It then reads the handler address from a vector table and hands back a new register set: the handler's program counter and program bank, a status word with the level mask raised to the accepted level and the system-stack flag set, and the lowered stack pointer.

On a return command the block reads the same twelve bytes back in the opposite order and presents the restored register set. Because the level mask lives inside the status word, returning also restores the mask. If the accepted request has its service-select bit set, the sequencer touches no memory and only emits a one-cycle handoff pulse toward the automatic transfer service.

The memory port is a simple byte port with a write enable, a read enable, a 24-bit address (stack bank in the upper 8 bits, stack pointer in the lower 16) and read data that is valid in the same cycle as the address.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, done_o, xfer_o, mem_we_o and mem_re_o are all 0 and stay 0 while no command arrives.
- R2: An accept with acc_xfer_i=0 writes 12 bytes, one per clock, using the register values sampled at the accept edge; write k (k=0..11) goes to address {sbank_i, sptr_i-1-k} (16-bit wrap), and the bytes in push order are stat[15:8], stat[7:0], pc[15:8], pc[7:0], pbank, dbank, xbank, dpage, accum[31:24], accum[23:16], accum[15:8], accum[7:0].
- R3: After the pushes the block reads three bytes starting at V = VEC_BASE - 4*acc_num_i: V gives pc_o[7:0], V+1 gives pc_o[15:8], V+2 gives pbank_o.
- R4: On entry completion stat_o equals the captured status with bits [15:13] replaced by the accepted level and bit 5 set to 1, sptr_o equals sptr_i-12, and accum_o, dpage_o, xbank_o, dbank_o equal the captured values.
- R5: done_o is a one-cycle pulse, visible after the 15th clock edge following the accept edge on entry and after the 12th clock edge following the return edge on return.
- R6: A return command reads 12 bytes at {sbank_i, sptr_i+j} for j=0..11 and restores them in the reverse of the push order; on completion every register output equals the frame contents and sptr_o equals sptr_i+12.
- R7: An accept with acc_xfer_i=1 produces a one-cycle xfer_o pulse after the accept edge, no memory access and no done_o.
- R8: Accept and return commands arriving while a sequence runs are ignored; when both arrive together in an idle cycle, the accept is taken.
- R9: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | Core accepted an interrupt request |
| acc_lvl_i | input | LVL_W | Level of the accepted request |
| acc_num_i | input | NUM_W | Source number of the accepted request |
| acc_xfer_i | input | 1 | Service-select bit of the accepted source |
| reti_i | input | 1 | Return-from-interrupt command |
| accum_i | input | 32 | Accumulator value |
| dpage_i | input | 8 | Direct page register |
| xbank_i | input | 8 | Additional data bank register |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| pc_i | input | 16 | Program counter |
| stat_i | input | 16 | Processor status word |
| sbank_i | input | 8 | System stack bank |
| sptr_i | input | 16 | System stack pointer |
| mem_we_o | output | 1 | Byte write enable |
| mem_re_o | output | 1 | Byte read enable |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read |
| accum_o | output | 32 | Resulting accumulator |
| dpage_o | output | 8 | Resulting direct page |
| xbank_o | output | 8 | Resulting additional data bank |
| dbank_o | output | 8 | Resulting data bank |
| pbank_o | output | 8 | Resulting program bank |
| pc_o | output | 16 | Resulting program counter |
| stat_o | output | 16 | Resulting status word |
| sptr_o | output | 16 | Resulting system stack pointer |
| done_o | output | 1 | One-cycle completion pulse |
| xfer_o | output | 1 | One-cycle handoff to the transfer service |

## Verification
The bench builds the block with its defaults, a 6-bit source number, a 3-bit level and a vector base of 0xFFFFFC, so source 0 and source 63 span the whole 256-byte vector page and levels 0 and 7 reach both ends of the mask field. Stack pointers near zero are used to bring the 16-bit wrap of the pre-decrement into reach, and random register contents with inputs scrambled after the command edge show that the frame comes from the captured values.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int FRAME_BYTES = 12;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int PTR_W       = 16;
  localparam int BANK_W      = 8;
  localparam int ADDR_W      = PTR_W + BANK_W;
  // bit positions of each register inside the frame vector
  localparam int F_ACC  = 0;
  localparam int F_DPG  = 32;
  localparam int F_XBK  = 40;
  localparam int F_DBK  = 48;
  localparam int F_PBK  = 56;
  localparam int F_PC   = 64;
  localparam int F_STAT = 80;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2,
    ST_POP  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/irq_step_ctr.sv
module irq_step_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_frame_mux.sv
module irq_frame_mux #(
  parameter int NBYTES = 12,
  parameter int IW     = 4
) (
  input  logic [8*NBYTES-1:0] frame_i,
  input  logic [IW-1:0]       idx_i,
  output logic [7:0]          byte_o
);
  logic [7:0] lane [NBYTES];

  // push order index g selects bytes from the top of the vector downwards
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = frame_i[8*(NBYTES-g)-1 -: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx_i == IW'(i)) byte_o = lane[i];
    end
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int          NUM_W    = 6,
  parameter int          LVL_W    = 3,
  parameter int          ILM_LSB  = 13,
  parameter int          SSEL_BIT = 5,
  parameter logic [23:0] VEC_BASE = 24'hFFFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [LVL_W-1:0] acc_lvl_i,
  input  logic [NUM_W-1:0] acc_num_i,
  input  logic             acc_xfer_i,
  input  logic             reti_i,
  input  logic [31:0]      accum_i,
  input  logic [7:0]       dpage_i,
  input  logic [7:0]       xbank_i,
  input  logic [7:0]       dbank_i,
  input  logic [7:0]       pbank_i,
  input  logic [15:0]      pc_i,
  input  logic [15:0]      stat_i,
  input  logic [7:0]       sbank_i,
  input  logic [15:0]      sptr_i,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [23:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic [31:0]      accum_o,
  output logic [7:0]       dpage_o,
  output logic [7:0]       xbank_o,
  output logic [7:0]       dbank_o,
  output logic [7:0]       pbank_o,
  output logic [15:0]      pc_o,
  output logic [15:0]      stat_o,
  output logic [15:0]      sptr_o,
  output logic             done_o,
  output logic             xfer_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] VEC_LAST = IDX_W'(2);
  localparam int               MASK_TOP = F_STAT + ILM_LSB + LVL_W - 1;

  seq_st_t              st_q, st_d;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic [BANK_W-1:0]    sbank_q, sbank_d;
  logic [PTR_W-1:0]     sptr_q, sptr_d;
  logic [LVL_W-1:0]     lvl_q, lvl_d;
  logic [ADDR_W-1:0]    vaddr_q, vaddr_d;
  logic                 done_q, done_d;
  logic                 xfer_q, xfer_d;
  logic                 cnt_clr, cnt_en;
  logic [IDX_W-1:0]     cnt;
  logic [7:0]           push_byte;

  irq_step_ctr #(.W(IDX_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  irq_frame_mux #(.NBYTES(FRAME_BYTES), .IW(IDX_W)) u_mux (
    .frame_i (frame_q),
    .idx_i   (cnt),
    .byte_o  (push_byte)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    frame_d    = frame_q;
    sbank_d    = sbank_q;
    sptr_d     = sptr_q;
    lvl_d      = lvl_q;
    vaddr_d    = vaddr_q;
    done_d     = 1'b0;
    xfer_d     = 1'b0;
    cnt_clr    = 1'b0;
    cnt_en     = 1'b0;
    mem_we_o   = 1'b0;
    mem_re_o   = 1'b0;
    mem_addr_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_i) begin
          if (acc_xfer_i) begin
            xfer_d = 1'b1;
          end else begin
            st_d    = ST_PUSH;
            frame_d = {stat_i, pc_i, pbank_i, dbank_i, xbank_i, dpage_i, accum_i};
            sbank_d = sbank_i;
            sptr_d  = sptr_i;
            lvl_d   = acc_lvl_i;
            vaddr_d = VEC_BASE - ADDR_W'({acc_num_i, 2'b00});
            cnt_clr = 1'b1;
          end
        end else if (reti_i) begin
          st_d    = ST_POP;
          sbank_d = sbank_i;
          sptr_d  = sptr_i;
          cnt_clr = 1'b1;
        end
      end
      ST_PUSH: begin
        mem_we_o   = 1'b1;
        mem_addr_o = {sbank_q, sptr_q - 1'b1};
        sptr_d     = sptr_q - 1'b1;
        cnt_en     = 1'b1;
        if (cnt == LAST_IDX) begin
          st_d    = ST_VEC;
          cnt_clr = 1'b1;
        end
      end
      ST_VEC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vaddr_q + ADDR_W'(cnt);
        cnt_en     = 1'b1;
        case (cnt)
          IDX_W'(0): frame_d[F_PC +: 8]     = mem_rdata_i;
          IDX_W'(1): frame_d[F_PC + 8 +: 8] = mem_rdata_i;
          default:   frame_d[F_PBK +: 8]    = mem_rdata_i;
        endcase
        if (cnt == VEC_LAST) begin
          frame_d[MASK_TOP -: LVL_W]    = lvl_q;
          frame_d[F_STAT + SSEL_BIT]    = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_POP: begin
        mem_re_o   = 1'b1;
        mem_addr_o = {sbank_q, sptr_q};
        sptr_d     = sptr_q + 1'b1;
        cnt_en     = 1'b1;
        frame_d[{cnt, 3'b000} +: 8] = mem_rdata_i;
        if (cnt == LAST_IDX) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= '0;
      sbank_q <= '0;
      sptr_q  <= '0;
      lvl_q   <= '0;
      vaddr_q <= '0;
      done_q  <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_d;
      sbank_q <= sbank_d;
      sptr_q  <= sptr_d;
      lvl_q   <= lvl_d;
      vaddr_q <= vaddr_d;
      done_q  <= done_d;
      xfer_q  <= xfer_d;
    end
  end

  assign mem_wdata_o = push_byte;
  assign accum_o = frame_q[F_ACC  +: 32];
  assign dpage_o = frame_q[F_DPG  +: 8];
  assign xbank_o = frame_q[F_XBK  +: 8];
  assign dbank_o = frame_q[F_DBK  +: 8];
  assign pbank_o = frame_q[F_PBK  +: 8];
  assign pc_o    = frame_q[F_PC   +: 16];
  assign stat_o  = frame_q[F_STAT +: 16];
  assign sptr_o  = sptr_q;
  assign done_o  = done_q;
  assign xfer_o  = xfer_q;

  // R5: completion strobe lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: one byte transfer direction per cycle
  a_r9_no_we_re: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R7: handoff never overlaps a stack access
  a_r7_xfer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> (!mem_we_o && !mem_re_o && !done_o));

  // R2: consecutive pushes step the pointer down by one
  a_r2_push_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[PTR_W-1:0] == $past(mem_addr_o[PTR_W-1:0]) - 16'd1));

  // R6: consecutive pops step the pointer up by one
  a_r6_pop_asc: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POP && $past(st_q) == ST_POP) |->
      (mem_addr_o[PTR_W-1:0] == $past(mem_addr_o[PTR_W-1:0]) + 16'd1));

  // R8: a running sequence is not restarted by a new command
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH && cnt != LAST_IDX) |=> (st_q == ST_PUSH));
endmodule

// File: tb/irq_ctx_seq_tb.sv
module irq_ctx_seq_tb_top;
  localparam logic [23:0] VBASE = 24'hFFFFFC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        accept, xfer_sel, reti;
  logic [2:0]  lvl;
  logic [5:0]  num;
  logic [31:0] accum;
  logic [7:0]  dpage, xbank, dbank, pbank, sbank;
  logic [15:0] pc, stat, sptr;
  logic        mem_we, mem_re;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [31:0] accum_o;
  logic [7:0]  dpage_o, xbank_o, dbank_o, pbank_o;
  logic [15:0] pc_o, stat_o, sptr_o;
  logic        done, xfer_o;

  int checks = 0;
  int errs   = 0;
  int wr_tot = 0;
  int rd_tot = 0;
  int done_tot = 0;
  bit finished = 0;
  logic [7:0] stk [0:1023];

  always #2 clk = ~clk;

  irq_ctx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .acc_lvl_i(lvl), .acc_num_i(num),
    .acc_xfer_i(xfer_sel), .reti_i(reti), .accum_i(accum), .dpage_i(dpage),
    .xbank_i(xbank), .dbank_i(dbank), .pbank_i(pbank), .pc_i(pc), .stat_i(stat),
    .sbank_i(sbank), .sptr_i(sptr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .accum_o(accum_o), .dpage_o(dpage_o), .xbank_o(xbank_o), .dbank_o(dbank_o),
    .pbank_o(pbank_o), .pc_o(pc_o), .stat_o(stat_o), .sptr_o(sptr_o),
    .done_o(done), .xfer_o(xfer_o)
  );

  function automatic logic [7:0] vec_byte(input logic [23:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[1:0], 6'b0};
  endfunction

  function automatic logic [7:0] rd_model(input logic [23:0] a);
    if (a[23:16] == 8'hFF) return vec_byte(a);
    return stk[a[9:0]];
  endfunction

  assign mem_rdata = rd_model(mem_addr);

  always @(posedge clk) begin
    if (mem_we) stk[mem_addr[9:0]] <= mem_wdata;
    if (mem_we) wr_tot <= wr_tot + 1;
    if (mem_re) rd_tot <= rd_tot + 1;
    if (done)   done_tot <= done_tot + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scramble();
    accum = $urandom; dpage = 8'($urandom); xbank = 8'($urandom); dbank = 8'($urandom);
    pbank = 8'($urandom); pc = 16'($urandom); stat = 16'($urandom);
    sptr = 16'($urandom); sbank = 8'($urandom); lvl = 3'($urandom); num = 6'($urandom);
  endtask

  // frame saved by the last entry, for the following return
  logic [95:0] saved_frame;
  logic [15:0] saved_sptr;

  task automatic run_entry(input logic [31:0] a, input logic [7:0] dp, xb, db, pb,
                           input logic [15:0] p, s, sp, input logic [7:0] sb,
                           input logic [2:0] l, input logic [5:0] n,
                           input bit poke, input bit both);
    int w0, r0, d0, lat;
    logic [95:0] fr;
    logic [23:0] v;
    logic [15:0] exp_stat;
    @(negedge clk);
    accum = a; dpage = dp; xbank = xb; dbank = db; pbank = pb; pc = p; stat = s;
    sptr = sp; sbank = sb; lvl = l; num = n; xfer_sel = 1'b0; accept = 1'b1;
    reti = both;
    w0 = wr_tot; r0 = rd_tot; d0 = done_tot;
    @(posedge clk);
    @(negedge clk);
    accept = 1'b0; reti = 1'b0;
    scramble();
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (poke && i == 4) begin accept = 1'b1; reti = 1'b1; end
      if (poke && i == 5) begin accept = 1'b0; reti = 1'b0; end
      if (done) begin lat = i; break; end
    end
    accept = 1'b0; reti = 1'b0;
    chk(lat == 15, "R5 entry latency", 64'(lat), 64'd15);
    chk(wr_tot - w0 == 12, poke ? "R8 writes while busy" : "R2 write count", 64'(wr_tot - w0), 64'd12);
    chk(rd_tot - r0 == 3, "R3 vector reads", 64'(rd_tot - r0), 64'd3);
    fr = {s, p, pb, db, xb, dp, a};
    for (int k = 0; k < 12; k++) begin
      logic [15:0] ad;
      ad = sp - 16'(k + 1);
      chk(stk[ad[9:0]] == fr[95 - 8*k -: 8], "R2 frame byte", 64'(stk[ad[9:0]]), 64'(fr[95 - 8*k -: 8]));
    end
    v = VBASE - {16'd0, n, 2'b00};
    chk(pc_o == {vec_byte(v + 24'd1), vec_byte(v)}, "R3 handler pc", 64'(pc_o), 64'({vec_byte(v + 24'd1), vec_byte(v)}));
    chk(pbank_o == vec_byte(v + 24'd2), "R3 handler bank", 64'(pbank_o), 64'(vec_byte(v + 24'd2)));
    exp_stat = (s & 16'h1FDF) | {l, 13'd0} | 16'h0020;
    chk(stat_o == exp_stat, "R4 status mask and stack flag", 64'(stat_o), 64'(exp_stat));
    chk(sptr_o == sp - 16'd12, "R4 stack pointer", 64'(sptr_o), 64'(sp - 16'd12));
    chk({accum_o, dpage_o, xbank_o, dbank_o} == {a, dp, xb, db}, "R4 unchanged registers",
        64'({accum_o, dpage_o, xbank_o, dbank_o}), 64'({a, dp, xb, db}));
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R5 done single cycle", 64'(done), 64'd0);
    chk(done_tot - d0 == 1, "R8 one completion", 64'(done_tot - d0), 64'd1);
    saved_frame = fr;
    saved_sptr  = sp;
  endtask

  task automatic run_return(input logic [7:0] sb, input logic [15:0] sp);
    int r0, w0, lat;
    @(negedge clk);
    scramble();
    sbank = sb; sptr = sp; reti = 1'b1; accept = 1'b0;
    r0 = rd_tot; w0 = wr_tot;
    @(posedge clk);
    @(negedge clk);
    reti = 1'b0;
    scramble();
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
    chk(lat == 12, "R5 return latency", 64'(lat), 64'd12);
    chk(rd_tot - r0 == 12 && wr_tot == w0, "R6 pop count", 64'(rd_tot - r0), 64'd12);
    chk({stat_o, pc_o, pbank_o, dbank_o, xbank_o, dpage_o, accum_o} == saved_frame, "R6 restored frame",
        64'({stat_o, pc_o, pbank_o}), 64'(saved_frame[95:56]));
    chk(accum_o == saved_frame[31:0], "R6 restored accumulator", 64'(accum_o), 64'(saved_frame[31:0]));
    chk(sptr_o == sp + 16'd12, "R6 stack pointer", 64'(sptr_o), 64'(sp + 16'd12));
  endtask

  task automatic run_xfer();
    int w0, r0, d0;
    @(negedge clk);
    scramble();
    xfer_sel = 1'b1; accept = 1'b1;
    w0 = wr_tot; r0 = rd_tot; d0 = done_tot;
    @(posedge clk);
    @(negedge clk);
    accept = 1'b0; xfer_sel = 1'b0;
    chk(xfer_o, "R7 handoff pulse", 64'(xfer_o), 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk(!xfer_o, "R7 handoff one cycle", 64'(xfer_o), 64'd0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(wr_tot == w0 && rd_tot == r0 && done_tot == d0, "R7 no access",
        64'(wr_tot - w0 + rd_tot - r0 + done_tot - d0), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) stk[i] = 8'h00;
    rst_n = 1'b0; accept = 1'b0; reti = 1'b0; xfer_sel = 1'b0;
    scramble();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: idle after reset
    chk(!done && !xfer_o && !mem_we && !mem_re && wr_tot == 0 && rd_tot == 0, "R1 reset state",
        64'({done, xfer_o, mem_we, mem_re}), 64'd0);

    // directed corners: source 0 / level 7, source 63 / level 0, pointer wrap
    run_entry(32'h01234567, 8'h11, 8'h22, 8'h33, 8'h44, 16'hBEEF, 16'hFFFF, 16'h0200, 8'h10, 3'd7, 6'd0, 0, 0);
    run_return(8'h10, saved_sptr - 16'd12);
    run_entry(32'hDEADBEEF, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 16'h1234, 16'h0000, 16'h0005, 8'h20, 3'd0, 6'd63, 0, 0);
    run_return(8'h20, saved_sptr - 16'd12);
    // R8: commands during a running entry, and accept beating return
    run_entry(32'hCAFEF00D, 8'h01, 8'h02, 8'h03, 8'h04, 16'h8000, 16'h5A5A, 16'h0300, 8'h30, 3'd4, 6'd17, 1, 1);
    run_return(8'h30, saved_sptr - 16'd12);
    run_xfer();

    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 4) == 0) run_xfer();
      run_entry($urandom, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom_range(16'h0040, 16'hFFF0)),
                8'($urandom_range(0, 254)), 3'($urandom), 6'($urandom), 0, 0);
      run_return(sbank_keep(), saved_sptr - 16'd12);
    end

    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!mem_we && !mem_re && !done, "R1 quiet when idle", 64'({mem_we, mem_re, done}), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  // return uses the bank the last entry saved into; track it here
  logic [7:0] last_bank;
  always @(posedge clk) if (mem_we) last_bank <= mem_addr[23:16];
  function automatic logic [7:0] sbank_keep();
    return last_bank;
  endfunction
endmodule